// File: doc/BRIEF.md
# Audio Stream Run-State Controller

This block is the control state machine for one direction (transmit or receive) of a block-based serial audio stream. Software-facing logic sends it trigger commands (start, stop, drain, drop, prepare) and configure requests. The sample datapath reports its current queue occupancy, the end of each block, and underrun or overrun events. From these the controller decides when the serial engine runs, when the block queue must be flushed, whether new blocks may be written and whether a read must be refused.

The three ways of ending a stream differ in timing and in what happens to the queue. Stop finishes the block in progress and keeps the rest for a later start. Drain keeps streaming until the transmit queue is empty. Drop halts at once and discards the queue. A fault latches an error state that only an explicit prepare (or a drop) can clear. Commands that are illegal in the current state leave it unchanged and pulse an error response for one cycle. The `IS_TX` parameter selects the direction-specific rules, and `DEPTH` sets the queue capacity in blocks (at least two).

Top module: `stream_run_ctl`

## Requirements
- R1: After reset the state is NOT_READY (code 0), and `run_en`, `flush` and `cmd_err` are low. State codes are NOT_READY=0, READY=1, RUNNING=2, STOPPING=3, ERROR=4.
- R2: A configure request in NOT_READY or READY moves to READY, or to NOT_READY when `cfg_rate_zero` is set. In any other state it is refused as illegal.
- R3: START (op 0) is legal only in READY and moves to RUNNING. On transmit it also needs `q_level` to be non-zero. `run_en` is high exactly in RUNNING and STOPPING.
- R4: STOP (op 1) is legal only in RUNNING. It moves to STOPPING and returns to READY on the next `blk_end` pulse. The queue is kept, so a later START resumes.
- R5: DRAIN (op 2) is legal only in RUNNING and moves to STOPPING. On transmit the state returns to READY once `q_level` reads zero. On receive, DRAIN behaves exactly like STOP.
- R6: DROP (op 3) is legal in every state except NOT_READY. It moves to READY in the next cycle and raises `flush` for exactly that one cycle.
- R7: `xrun` in RUNNING or STOPPING moves to ERROR and is ignored in other states. PREPARE (op 4) is legal only in ERROR and moves to READY.
- R8: `wr_ready` is high only in READY or RUNNING while `q_level` is below `DEPTH`. A full queue back-pressures writes.
- R9: `rd_err` is high when `rd_req` is asserted in NOT_READY, or in ERROR with `q_level` zero. Reads of queued data in ERROR are allowed.
- R10: An illegal command, including op codes 5 to 7, leaves the state unchanged and raises `cmd_err` for one cycle.
- R11: In one cycle a command takes priority over a configure request, which is then ignored without error. A configure request takes priority over `xrun`, and `xrun` over the completion of STOPPING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_req | input | 1 | Trigger command strobe |
| cmd_op | input | 3 | Command code: 0 start, 1 stop, 2 drain, 3 drop, 4 prepare |
| cfg_req | input | 1 | Configure request strobe |
| cfg_rate_zero | input | 1 | Configure request carries a zero frame rate |
| q_level | input | $clog2(DEPTH+1) | Blocks currently queued, from the datapath |
| blk_end | input | 1 | Datapath finished the current block |
| xrun | input | 1 | Datapath underrun (transmit) or overrun (receive) |
| rd_req | input | 1 | Read of a queued block requested |
| state | output | 3 | Current run state |
| run_en | output | 1 | Serial engine enable |
| flush | output | 1 | One-cycle queue discard request |
| cmd_err | output | 1 | One-cycle illegal command response |
| wr_ready | output | 1 | A block write may be accepted |
| rd_err | output | 1 | Read refused with an I/O error |

## Verification
The assertions assume that `cmd_op` is only looked at while `cmd_req` is high, and that `q_level` never exceeds `DEPTH`. The bench's datapath stand-in keeps its queue count within 0 to `DEPTH` at all times. All other strobes, including commands, configure requests, fault events and block ends, are allowed to coincide freely, so the priority order is exercised. A transmit instance and a receive instance share the same stimulus, so the direction-specific start and drain rules can be compared under identical sequences.

// File: rtl/stream_run_ctl.sv
module stream_run_ctl #(
  parameter int DEPTH = 4,
  parameter bit IS_TX = 1'b1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_req,
  input  logic [2:0]    cmd_op,
  input  logic          cfg_req,
  input  logic          cfg_rate_zero,
  input  logic [LW-1:0] q_level,
  input  logic          blk_end,
  input  logic          xrun,
  input  logic          rd_req,
  output logic [2:0]    state,
  output logic          run_en,
  output logic          flush,
  output logic          cmd_err,
  output logic          wr_ready,
  output logic          rd_err
);

  localparam logic [2:0] S_IDLE = 3'd0, S_RDY = 3'd1, S_RUN = 3'd2,
                         S_STOP = 3'd3, S_ERR = 3'd4;
  localparam logic [2:0] OP_START = 3'd0, OP_STOP = 3'd1, OP_DRAIN = 3'd2,
                         OP_DROP = 3'd3, OP_PREP = 3'd4;
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [2:0] st_n;
  logic       drain_q, drain_n, err_n, flush_n;
  logic       streaming;

  assign streaming = (state == S_RUN) || (state == S_STOP);

  always_comb begin
    st_n    = state;
    drain_n = drain_q;
    err_n   = 1'b0;
    flush_n = 1'b0;
    if (cmd_req) begin
      case (cmd_op)
        OP_START:
          if (state == S_RDY && (!IS_TX || q_level != '0)) st_n = S_RUN;
          else err_n = 1'b1;
        OP_STOP, OP_DRAIN:
          if (state == S_RUN) begin
            st_n    = S_STOP;
            drain_n = (cmd_op == OP_DRAIN) && IS_TX;
          end else err_n = 1'b1;
        OP_DROP:
          if (state != S_IDLE) begin
            st_n    = S_RDY;
            flush_n = 1'b1;
          end else err_n = 1'b1;
        OP_PREP:
          if (state == S_ERR) st_n = S_RDY;
          else err_n = 1'b1;
        default: err_n = 1'b1;
      endcase
    end else if (cfg_req) begin
      if (state == S_IDLE || state == S_RDY) st_n = cfg_rate_zero ? S_IDLE : S_RDY;
      else err_n = 1'b1;
    end else if (xrun && streaming) begin
      st_n = S_ERR;
    end else if (state == S_STOP && (drain_q ? (q_level == '0) : blk_end)) begin
      st_n = S_RDY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      drain_q <= 1'b0;
      cmd_err <= 1'b0;
      flush   <= 1'b0;
    end else begin
      state   <= st_n;
      drain_q <= drain_n;
      cmd_err <= err_n;
      flush   <= flush_n;
    end
  end

  assign run_en   = streaming;
  assign wr_ready = (state == S_RDY || state == S_RUN) && (q_level < FULL);
  assign rd_err   = rd_req && (state == S_IDLE || (state == S_ERR && q_level == '0));

  AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> ($past(cmd_req) && $past(cmd_op) == OP_START)); // R3
  AST_FLUSH_LANDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (state == S_RDY && $past(cmd_req) && $past(cmd_op) == OP_DROP)); // R6
  AST_ERR_ENTRY_XRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ERR && $past(state) != S_ERR) |-> $past(xrun)); // R7
  AST_ERR_EXIT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_ERR && state != S_ERR) |->
      ($past(cmd_req) && ($past(cmd_op) == OP_PREP || $past(cmd_op) == OP_DROP))); // R7
  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $stable(state)); // R10

endmodule

// File: tb/stream_run_ctl_tb.sv
module stream_run_ctl_tb;
  localparam int DEPTH = 4;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_req = 0, cfg_req = 0, cfg_rate_zero = 0, blk_end = 0, xrun = 0, rd_req = 0;
  logic [2:0] cmd_op = 0;
  logic [LW-1:0] q_level = 0;

  logic [2:0] d_state [2];
  logic d_run [2], d_flush [2], d_err [2], d_wr [2], d_rderr [2];

  int checks = 0, errors = 0;
  int m_st [2], m_err [2], m_flush [2];
  bit m_drain [2];

  always #5 clk = ~clk;

  stream_run_ctl #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_op(cmd_op), .cfg_req(cfg_req),
    .cfg_rate_zero(cfg_rate_zero), .q_level(q_level), .blk_end(blk_end), .xrun(xrun),
    .rd_req(rd_req), .state(d_state[0]), .run_en(d_run[0]), .flush(d_flush[0]),
    .cmd_err(d_err[0]), .wr_ready(d_wr[0]), .rd_err(d_rderr[0]));

  stream_run_ctl #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_dut_rx (
    .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_op(cmd_op), .cfg_req(cfg_req),
    .cfg_rate_zero(cfg_rate_zero), .q_level(q_level), .blk_end(blk_end), .xrun(xrun),
    .rd_req(rd_req), .state(d_state[1]), .run_en(d_run[1]), .flush(d_flush[1]),
    .cmd_err(d_err[1]), .wr_ready(d_wr[1]), .rd_err(d_rderr[1]));

  // Reference model: behavioural, one entry per direction (0 = transmit, 1 = receive)
  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      int nx; bit tx;
      tx = (i == 0);
      m_err[i] = 0;
      m_flush[i] = 0;
      nx = m_st[i];
      if (!rst_n) begin
        m_st[i] = 0; m_drain[i] = 0;
        continue;
      end
      if (cmd_req) begin                                   // R11 command first
        if (cmd_op == 0 && m_st[i] == 1 && (!tx || q_level > 0)) nx = 2;          // R3
        else if ((cmd_op == 1 || cmd_op == 2) && m_st[i] == 2) begin              // R4 R5
          nx = 3; m_drain[i] = (cmd_op == 2) && tx;
        end
        else if (cmd_op == 3 && m_st[i] != 0) begin nx = 1; m_flush[i] = 1; end  // R6
        else if (cmd_op == 4 && m_st[i] == 4) nx = 1;                            // R7
        else m_err[i] = 1;                                                      // R10
      end else if (cfg_req) begin                                              // R2
        if (m_st[i] <= 1) nx = cfg_rate_zero ? 0 : 1;
        else m_err[i] = 1;
      end else if (xrun && (m_st[i] == 2 || m_st[i] == 3)) nx = 4;            // R7
      else if (m_st[i] == 3) begin
        if (m_drain[i] ? (q_level == 0) : blk_end) nx = 1;
      end
      m_st[i] = nx;
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < 2; i++) begin
      int ewr, erd;
      ewr = ((m_st[i] == 1 || m_st[i] == 2) && q_level < DEPTH) ? 1 : 0;
      erd = (rd_req && (m_st[i] == 0 || (m_st[i] == 4 && q_level == 0))) ? 1 : 0;
      cmp(i == 0 ? "R2/R4/R5/R7/R11 state tx" : "R2/R4/R5/R7/R11 state rx", d_state[i], m_st[i]);
      cmp("R3 run_en", d_run[i], (m_st[i] == 2 || m_st[i] == 3) ? 1 : 0);
      cmp("R6 flush", d_flush[i], m_flush[i]);
      cmp("R10 cmd_err", d_err[i], m_err[i]);
      cmp("R8 wr_ready", d_wr[i], ewr);
      cmp("R9 rd_err", d_rderr[i], erd);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) compare_all();
    cmd_req = 0; cfg_req = 0; xrun = 0; blk_end = 0; rd_req = 0;
  endtask

  task automatic cmd(input int op);
    cmd_req = 1; cmd_op = 3'(op); step();
  endtask

  task automatic cfg(input bit zero);
    cfg_req = 1; cfg_rate_zero = zero; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    @(negedge clk);
    cmp("R1 reset state", d_state[0], 0);
    cmp("R1 reset run_en", d_run[0], 0);
    cmp("R1 reset flush", d_flush[0], 0);
    cmp("R1 reset cmd_err", d_err[0], 0);
    rd_req = 1; step();                 // R9 read in NOT_READY
    cmd(3);                             // R6 drop illegal in NOT_READY -> R10
    cmd(0);                             // R10 start illegal in NOT_READY
    cfg(0);                             // R2 -> READY
    cmd(0);                             // R3 tx refused with empty queue, rx starts
    q_level = 2; step();
    cmd(3);                             // R6 drop from READY/RUNNING
    cmd(0);                             // R3 start both
    cfg(0);                             // R2 illegal while running
    cmd(1); step();                     // R4 stop
    blk_end = 1; step(); step();        // R4 back to READY
    cmd(0); cmd(2);                     // R5 drain
    blk_end = 1; step();                // rx finishes like stop, tx waits
    q_level = 1; step();
    q_level = 0; step(); step();        // R5 tx done
    q_level = 4; step();                // R8 full
    cmd(0); q_level = 3; step();
    xrun = 1; step();                   // R7 -> ERROR
    rd_req = 1; step();                 // R9 queued read allowed
    q_level = 0; rd_req = 1; step();    // R9 empty read refused
    cmd(0);                             // R10 start in ERROR
    cmd(4);                             // R7 prepare
    cmd(4);                             // R10 prepare outside ERROR
    cmd(6); cmd(7); cmd(5);             // R10 undefined codes
    cmd_req = 1; cmd_op = 3; cfg_req = 1; cfg_rate_zero = 1; step(); // R11
    cfg(1);                             // R2 -> NOT_READY
    xrun = 1; step();                   // R7 ignored when idle
    // Mixed stimulus phase
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = int'($urandom_range(99, 0));
      if (r < 12) begin cmd_req = 1; cmd_op = 3'($urandom_range(7, 0)); end
      if ($urandom_range(19, 0) == 0) begin cfg_req = 1; cfg_rate_zero = ($urandom_range(3, 0) == 0); end
      if ($urandom_range(29, 0) == 0) xrun = 1;
      if ($urandom_range(3, 0) == 0) blk_end = 1;
      if ($urandom_range(3, 0) == 0) rd_req = 1;
      if ($urandom_range(3, 0) == 0) begin
        if ($urandom_range(1, 0) == 1 && q_level < DEPTH) q_level = q_level + 1'b1;
        else if (q_level > 0) q_level = q_level - 1'b1;
      end
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1900000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule